// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This block performs signed arithmetic on two two's-complement operands and never wraps. When a result leaves the representable range, the block pins it to the nearest limit. Four operations are offered. The plain pair adds or subtracts the operands. The doubling pair first doubles the second operand with its own clamp and then adds that value to the first operand, or subtracts it from the first operand, with a second clamp.

Each accepted operation is registered on the clock edge that follows its valid strobe. A sticky flag records that some clamp has happened since it was last cleared. Software-side logic or a neighbouring pipeline stage can read this flag after a batch of samples to find out whether any precision was lost. It can then drop the flag with a synchronous clear input.

Top module: `sat_addsub_unit`

## Requirements
- R1: Opcode 2'b00 returns opA + opB as a signed value, clamped to the signed range of W bits.
- R2: Opcode 2'b01 returns opA - opB as a signed value, clamped to the signed range of W bits.
- R3: Opcode 2'b10 first clamps 2*opB to the signed range, then returns opA plus that value, again clamped.
- R4: Opcode 2'b11 first clamps 2*opB to the signed range, then returns opA minus that value, again clamped.
- R5: A result above the range reads as the largest positive value (0x7FFFFFFF for W=32). A result below the range reads as the most negative value (0x80000000).
- R6: A clamp in the doubling step sets the sticky flag even when the following add or subtract fits in range.
- R7: The sticky flag sets on any clamp of an accepted operation and stays set across later non-clamping operations and idle cycles until a clear is given.
- R8: When a clear arrives in the same cycle as a clamping operation, the clear wins: the flag reads 0 afterwards, and the result is still registered.
- R9: The result and resValid update on the clock edge after inValid is high. While inValid is low, resValid reads 0 and the result holds its last value.
- R10: After reset the result reads 0 and both resValid and the sticky flag read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opCode | input | 2 | Operation select: 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| opA | input | W | First operand, signed |
| opB | input | W | Second operand, signed |
| clrSticky | input | 1 | Synchronous clear of the sticky flag |
| result | output | W | Registered clamped result |
| resValid | output | 1 | Result was loaded on the last edge |
| stickySat | output | 1 | Set once any clamp has occurred since the last clear |

## Verification
The sign assertions rely on opCode taking only the four defined values whenever inValid is high. They also rely on the operands being stable in the cycle of the strobe. The bench drives every input at the falling edge, so these conditions hold at each rising edge. It only uses the four legal codes. Before each table vector it pulses the clear in a cycle with no valid input, so every sticky expectation belongs to exactly one operation.

// File: rtl/satalu_pkg.sv
package satalu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } satOp_e;

  typedef struct packed {
    logic loadEn;
    logic useDouble;
    logic doSub;
    logic clearFlag;
  } satCtrl_t;

endpackage

// File: rtl/satalu_ctrl.sv
module satalu_ctrl
  import satalu_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opCode,
  input  logic       clrSticky,
  output satCtrl_t   strobes
);

  always_comb begin
    strobes.loadEn    = inValid;
    strobes.clearFlag = clrSticky;
    strobes.useDouble = 1'b0;
    strobes.doSub     = 1'b0;
    case (satOp_e'(opCode))
      OP_ADD:  ;
      OP_SUB:  strobes.doSub = 1'b1;
      OP_DADD: strobes.useDouble = 1'b1;
      OP_DSUB: begin
        strobes.useDouble = 1'b1;
        strobes.doSub     = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/satalu_dpath.sv
module satalu_dpath
  import satalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  satCtrl_t     strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         resValid,
  output logic         stickySat
);

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic         dblOvf;
  logic [W-1:0] dblVal;
  logic [W-1:0] operand;
  logic [W:0]   extA;
  logic [W:0]   extB;
  logic [W:0]   wide;
  logic         sumOvf;
  logic [W-1:0] nextRes;
  logic         anyClamp;

  // Doubling stage: overflow when the two top bits differ.
  always_comb begin
    dblOvf  = opB[W-1] ^ opB[W-2];
    dblVal  = dblOvf ? (opB[W-1] ? MIN_NEG : MAX_POS) : {opB[W-2:0], 1'b0};
    operand = strobes.useDouble ? dblVal : opB;
  end

  // Add/subtract stage with one guard bit.
  always_comb begin
    extA     = {opA[W-1], opA};
    extB     = {operand[W-1], operand};
    wide     = strobes.doSub ? (extA - extB) : (extA + extB);
    sumOvf   = wide[W] ^ wide[W-1];
    nextRes  = sumOvf ? (wide[W] ? MIN_NEG : MAX_POS) : wide[W-1:0];
    anyClamp = sumOvf | (strobes.useDouble & dblOvf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      resValid  <= 1'b0;
      stickySat <= 1'b0;
    end else begin
      resValid <= strobes.loadEn;
      if (strobes.loadEn) result <= nextRes;
      if (strobes.clearFlag) stickySat <= 1'b0;
      else if (strobes.loadEn && anyClamp) stickySat <= 1'b1;
    end
  end

endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import satalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic [1:0]   opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         clrSticky,
  output logic [W-1:0] result,
  output logic         resValid,
  output logic         stickySat
);

  satCtrl_t strobes;

  satalu_ctrl u_ctrl (
    .inValid  (inValid),
    .opCode   (opCode),
    .clrSticky(clrSticky),
    .strobes  (strobes)
  );

  satalu_dpath #(.W(W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .resValid (resValid),
    .stickySat(stickySat)
  );

endmodule

// File: rtl/satalu_chk.sv
module satalu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inValid,
  input logic [1:0]   opCode,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         clrSticky,
  input logic [W-1:0] result,
  input logic         resValid,
  input logic         stickySat
);

  assert_add_nonneg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 2'b00 && !opA[W-1] && !opB[W-1]) |=> !result[W-1]);

  assert_sub_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 2'b01 && !opA[W-1] && opB[W-1]) |=> !result[W-1]);

  assert_dadd_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 2'b10 && !opA[W-1] && !opB[W-1]) |=> !result[W-1]);

  assert_dsub_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 2'b11 && !opA[W-1] && opB[W-1]) |=> !result[W-1]);

  assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stickySat && !clrSticky) |=> stickySat);

  assert_idle_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inValid && !stickySat) |=> !stickySat);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clrSticky |=> !stickySat);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> resValid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!resValid && $stable(result)));

endmodule

bind sat_addsub_unit satalu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .clrSticky(clrSticky),
  .result   (result),
  .resValid (resValid),
  .stickySat(stickySat)
);

// File: tb/sat_addsub_unit_tb.sv
`timescale 1ns/1ps
module sat_addsub_unit_tb;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] expRes;
    logic        expSat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0},  // R1
    '{2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1},  // R1 R5
    '{2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1},  // R1 R5
    '{2'b00, 32'hFFFF_FFFE, 32'h0000_0003, 32'h0000_0001, 1'b0},  // R1
    '{2'b01, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007, 1'b0},  // R2
    '{2'b01, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b1},  // R2 R5
    '{2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1},  // R2 R5
    '{2'b01, 32'h0000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1},  // R2 R5
    '{2'b10, 32'h0000_0064, 32'h0000_0003, 32'h0000_006A, 1'b0},  // R3
    '{2'b10, 32'h0000_0000, 32'h4000_0000, 32'h7FFF_FFFF, 1'b1},  // R3 R6
    '{2'b10, 32'h8000_0000, 32'h4000_0000, 32'hFFFF_FFFF, 1'b1},  // R6
    '{2'b10, 32'h7FFF_FFF0, 32'h0000_0010, 32'h7FFF_FFFF, 1'b1},  // R3 R5
    '{2'b10, 32'h0000_0000, 32'hC000_0000, 32'h8000_0000, 1'b0},  // R3 exact
    '{2'b11, 32'h0000_0064, 32'h0000_0005, 32'h0000_005A, 1'b0},  // R4
    '{2'b11, 32'hFFFF_FFFF, 32'hC000_0000, 32'h7FFF_FFFF, 1'b0},  // R4 exact
    '{2'b11, 32'h0000_0000, 32'hBFFF_FFFF, 32'h7FFF_FFFF, 1'b1},  // R4 R5
    '{2'b11, 32'hFFFF_FFFF, 32'hA000_0000, 32'h7FFF_FFFF, 1'b1}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        clrSticky = 1'b0;
  logic [31:0] result;
  logic        resValid;
  logic        stickySat;

  int  checks = 0;
  int  fails = 0;
  bit  reported = 0;

  always #4 clk = ~clk;

  sat_addsub_unit #(.W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opCode(opCode),
    .opA(opA), .opB(opB), .clrSticky(clrSticky),
    .result(result), .resValid(resValid), .stickySat(stickySat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Drive one operation at a falling edge; outputs are read one falling edge later.
  task automatic drive(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic clr);
    @(negedge clk);
    inValid = 1'b1; opCode = op; opA = a; opB = b; clrSticky = clr;
    @(negedge clk);
    inValid = 1'b0; clrSticky = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    inValid = 1'b0; clrSticky = 1'b1;
    @(negedge clk);
    clrSticky = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 result", result, 32'h0);
    check("R10 resValid", {31'b0, resValid}, 32'h0);
    check("R10 sticky", {31'b0, stickySat}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      clearFlag();
      drive(VECS[i].op, VECS[i].a, VECS[i].b, 1'b0);
      check($sformatf("R1-4 vec%0d result", i), result, VECS[i].expRes);
      check($sformatf("R5/R6 vec%0d sticky", i), {31'b0, stickySat}, {31'b0, VECS[i].expSat});
      check($sformatf("R9 vec%0d resValid", i), {31'b0, resValid}, 32'h1);
    end

    // R9: idle cycle holds the result, resValid low
    opA = 32'h1234_5678; opB = 32'h0000_0001; opCode = 2'b00;
    @(negedge clk);
    check("R9 hold result", result, 32'h7FFF_FFFF);
    check("R9 idle resValid", {31'b0, resValid}, 32'h0);

    // R7: sticky persists through non-clamping ops and idle cycles
    clearFlag();
    drive(2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    drive(2'b00, 32'h0000_0001, 32'h0000_0001, 1'b0);
    check("R7 plain result", result, 32'h0000_0002);
    check("R7 sticky kept", {31'b0, stickySat}, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 sticky idle", {31'b0, stickySat}, 32'h1);

    // R8: clear together with a clamping op
    drive(2'b01, 32'h8000_0000, 32'h0000_0001, 1'b1);
    check("R8 sticky cleared", {31'b0, stickySat}, 32'h0);
    check("R8 result loaded", result, 32'h8000_0000);

    // R7: a clear pulse with no operation drops the flag
    drive(2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
    check("R7 set again", {31'b0, stickySat}, 32'h1);
    clearFlag();
    check("R7 cleared", {31'b0, stickySat}, 32'h0);

    // R10: reset mid-run returns to reset state
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset result", result, 32'h0);
    rst_n = 1'b1;
    finishRun();
  end

endmodule